// File: doc/BRIEF.md
# Interrupt Controller with Per-Source Line Steering

This block collects interrupt requests from two banks of sixteen level-sensitive sources and presents them to a processor on five interrupt lines. Every source has an enable bit and a 3-bit steering code that picks the line it drives. A line is active when at least one source steered to it is both raised and enabled. A 16-bit register port with two window selects gives software access. Window A holds bank A's state and all four steering registers. Window B holds bank B's state.

Software enables a source by setting its bit in the bank's enable register. It moves the source to another processor line by rewriting the source's steering code. To find which sources are raised, it reads the bank's live request register. The five line outputs are registered, so they follow their inputs one clock later.

Top module: `irq_steer`

## Requirements
- R1: Synchronous active-low reset has these effects:
  - Both enable registers become 0x0000 and `line_out` becomes 0.
  - Steering register 0 becomes 0x0040, so bank A source 2 goes to line 1.
  - Steering register 2 becomes 0x00C2, so bank B source 0 goes to line 2 and bank B source 2 goes to line 3.
  - Steering registers 1 and 3 become 0x0000.
- R2: Window A decodes these offsets:
  - 0x00: request (read only)
  - 0x04: steering register 0
  - 0x06: steering register 1
  - 0x0C: enable register
  - 0x1C: steering register 2
  - 0x1E: steering register 3
- R2 (continued): Window B decodes 0x00 (request) and 0x06 (enable). Any other offset reads 0x0000 and ignores writes. With no window selected, `bus_rdata` is 0x0000. When both selects are high, window A wins.
- R3: The bank A steering registers are 0 and 1, and the bank B steering registers are 2 and 3. Sources 0 to 4 of a bank use its first register, and sources 5 to 9 use its second. Source s uses bits [3k+2:3k] of that register, with k = s mod 5. Sources 10 to 15 always steer to line 0. Bit 15 of a steering register reads 0.
- R4: `line_out[n]` is 1 when at least one source in either bank meets all of these conditions: its request is 1, its enable bit is 1, and its steering code equals n.
- R5: A steering code of 5, 6 or 7 drives no line.
- R6: `line_out` is registered. A change in a request input, an enable register or a steering register shows on `line_out` after the next rising clock edge, and not before it.
- R7: A read of a request register returns the live level of that bank's source inputs. Writes to it change no state.
- R8: Enable registers read back all 16 bits last written. Steering registers read back bits 14:0 last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 16 | Bank A request levels |
| src_b | input | 16 | Bank B request levels |
| bus_sel_a | input | 1 | Window A select |
| bus_sel_b | input | 1 | Window B select |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| line_out | output | 5 | Processor interrupt lines |

## Verification
Single-source patterns show one source at a time on one line:
- Each is placed at a chosen field position, in each of the two banks.
- This exposes wrong field offsets or a wrong choice of register.

Multi-source patterns mix a raised but disabled source with enabled sources steered to different lines. They separate OR-tree faults from enable-gating faults. Steering codes 5 to 7, and sources above 9, check the unrouted and fixed-route cases. A long stretch of random requests, enables and bus writes (including unmapped offsets and dual selects) is compared clock by clock against a behavioural model. This catches timing slips of one cycle.

// File: rtl/irq_steer_pkg.sv
// Package irq_steer_pkg
// Shared sizes, register offsets and reset values for the steering
// interrupt controller. Offsets are byte offsets within a window.
package irq_steer_pkg;
    localparam int REG_W   = 16;                  // register width
    localparam int SRC_N   = 16;                  // sources per bank
    localparam int LINE_N  = 5;                   // processor lines
    localparam int SEL_W   = 3;                   // steering code width
    localparam int FIELDS  = 5;                   // codes per steering register
    localparam int RT_W    = FIELDS * SEL_W;      // used bits of a steering register
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_REQ    = 5'h00;
    localparam logic [ADDR_W-1:0] A_OFS_RT0  = 5'h04;
    localparam logic [ADDR_W-1:0] A_OFS_RT1  = 5'h06;
    localparam logic [ADDR_W-1:0] A_OFS_EN   = 5'h0C;
    localparam logic [ADDR_W-1:0] A_OFS_RT2  = 5'h1C;
    localparam logic [ADDR_W-1:0] A_OFS_RT3  = 5'h1E;
    localparam logic [ADDR_W-1:0] B_OFS_EN   = 5'h06;

    localparam logic [RT_W-1:0] RT0_RST = RT_W'(16'h0040);  // A src2 -> line 1
    localparam logic [RT_W-1:0] RT1_RST = '0;
    localparam logic [RT_W-1:0] RT2_RST = RT_W'(16'h00C2);  // B src0 -> 2, src2 -> 3
    localparam logic [RT_W-1:0] RT3_RST = '0;
endpackage

// File: rtl/irq_steer_regs.sv
// Module irq_steer_regs
// Register file for the two windows. It holds the two enable registers
// and the four steering registers, and returns read data combinationally.
// Request registers are not stored: a read returns the source inputs.
// Assumes: bus_wr is a one-cycle strobe, and window A wins when both
// selects are high.
module irq_steer_regs
    import irq_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [SRC_N-1:0]  src_a,
    input  logic [SRC_N-1:0]  src_b,
    output logic [REG_W-1:0]  rdata,
    output logic [SRC_N-1:0]  en_a,
    output logic [SRC_N-1:0]  en_b,
    output logic [RT_W-1:0]   rt0,
    output logic [RT_W-1:0]   rt1,
    output logic [RT_W-1:0]   rt2,
    output logic [RT_W-1:0]   rt3
);
    logic wr_a, wr_b;

    // Write qualification: window A has priority over window B.
    always_comb begin
        wr_a = wr && sel_a;
        wr_b = wr && sel_b && !sel_a;
    end

    // Register update: reset values, then decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_a <= '0;
            en_b <= '0;
            rt0  <= RT0_RST;
            rt1  <= RT1_RST;
            rt2  <= RT2_RST;
            rt3  <= RT3_RST;
        end else begin
            if (wr_a) begin
                case (addr)
                    A_OFS_RT0: rt0  <= wdata[RT_W-1:0];
                    A_OFS_RT1: rt1  <= wdata[RT_W-1:0];
                    A_OFS_EN:  en_a <= wdata[SRC_N-1:0];
                    A_OFS_RT2: rt2  <= wdata[RT_W-1:0];
                    A_OFS_RT3: rt3  <= wdata[RT_W-1:0];
                    default:   ;
                endcase
            end
            if (wr_b && addr == B_OFS_EN) begin
                en_b <= wdata[SRC_N-1:0];
            end
        end
    end

    // Read mux: live requests, stored registers, zero for unmapped offsets.
    always_comb begin
        rdata = '0;
        if (sel_a) begin
            case (addr)
                OFS_REQ:   rdata = REG_W'(src_a);
                A_OFS_RT0: rdata = REG_W'(rt0);
                A_OFS_RT1: rdata = REG_W'(rt1);
                A_OFS_EN:  rdata = REG_W'(en_a);
                A_OFS_RT2: rdata = REG_W'(rt2);
                A_OFS_RT3: rdata = REG_W'(rt3);
                default:   rdata = '0;
            endcase
        end else if (sel_b) begin
            case (addr)
                OFS_REQ:  rdata = REG_W'(src_b);
                B_OFS_EN: rdata = REG_W'(en_b);
                default:  rdata = '0;
            endcase
        end
    end

    // R1: the first cycle after reset shows the reset contents.
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_a == '0 && en_b == '0 && rt0 == RT0_RST && rt2 == RT2_RST))
        else $error("a_r1_reset_values");

    // R8: a write to the window A enable register is stored as written.
    a_r8_en_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a && wr && addr == A_OFS_EN) |=> (en_a == $past(wdata)))
        else $error("a_r8_en_readback");

    // R7: a write to the window A request offset leaves all state unchanged.
    a_r7_req_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a && wr && addr == OFS_REQ) |=>
        ($stable(en_a) && $stable(en_b) && $stable(rt0) && $stable(rt1) && $stable(rt2) && $stable(rt3)))
        else $error("a_r7_req_write_ignored");
endmodule

// File: rtl/irq_steer_bank.sv
// Module irq_steer_bank
// Combinational steering for one bank. It extracts each source's
// steering code and ORs the raised, enabled sources onto the line their
// code names. Codes that name no line (LINE_N and above) drive nothing.
// Sources at index 2*FIELDS and above have no code and use line 0.
// Assumes: rt_lo carries the codes of sources 0..FIELDS-1, and rt_hi
// carries the codes of sources FIELDS..2*FIELDS-1.
module irq_steer_bank #(
    parameter int SRC_N  = 16,
    parameter int LINE_N = 5,
    parameter int SEL_W  = 3,
    parameter int FIELDS = 5
) (
    input  logic [SRC_N-1:0]        req,
    input  logic [SRC_N-1:0]        en,
    input  logic [FIELDS*SEL_W-1:0] rt_lo,
    input  logic [FIELDS*SEL_W-1:0] rt_hi,
    output logic [LINE_N-1:0]       hit
);
    localparam int ROUTED = 2 * FIELDS;

    logic [SEL_W-1:0]  code [SRC_N];
    logic [SRC_N-1:0]  live;
    logic [SRC_N-1:0]  match [LINE_N];

    // Per-source code extraction, picked by where the source sits.
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        if (s < FIELDS) begin : g_lo
            assign code[s] = rt_lo[s*SEL_W +: SEL_W];
        end else if (s < ROUTED) begin : g_hi
            assign code[s] = rt_hi[(s-FIELDS)*SEL_W +: SEL_W];
        end else begin : g_fixed
            assign code[s] = '0;
        end
    end

    // Gate each request with its enable bit.
    always_comb live = req & en;

    // One OR tree per line over the sources whose code names it.
    for (genvar n = 0; n < LINE_N; n++) begin : g_line
        for (genvar s = 0; s < SRC_N; s++) begin : g_cmp
            assign match[n][s] = (code[s] == SEL_W'(n));
        end
        assign hit[n] = |(live & match[n]);
    end
endmodule

// File: rtl/irq_steer.sv
// Module irq_steer
// Top of the steering interrupt controller. It holds the register file,
// one steering block per bank, and the registered output lines. Each
// line is the OR of the two banks' results for that line.
// Assumes: the source inputs are synchronous to clk.
module irq_steer
    import irq_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_a,
    input  logic [SRC_N-1:0]  src_b,
    input  logic              bus_sel_a,
    input  logic              bus_sel_b,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [LINE_N-1:0] line_out
);
    logic [SRC_N-1:0]  en_a, en_b;
    logic [RT_W-1:0]   rt0, rt1, rt2, rt3;
    logic [LINE_N-1:0] hit_a, hit_b, line_next;

    irq_steer_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_a (bus_sel_a),
        .sel_b (bus_sel_b),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .src_a (src_a),
        .src_b (src_b),
        .rdata (bus_rdata),
        .en_a  (en_a),
        .en_b  (en_b),
        .rt0   (rt0),
        .rt1   (rt1),
        .rt2   (rt2),
        .rt3   (rt3)
    );

    irq_steer_bank #(.SRC_N(SRC_N), .LINE_N(LINE_N), .SEL_W(SEL_W), .FIELDS(FIELDS)) u_bank_a (
        .req   (src_a),
        .en    (en_a),
        .rt_lo (rt0),
        .rt_hi (rt1),
        .hit   (hit_a)
    );

    irq_steer_bank #(.SRC_N(SRC_N), .LINE_N(LINE_N), .SEL_W(SEL_W), .FIELDS(FIELDS)) u_bank_b (
        .req   (src_b),
        .en    (en_b),
        .rt_lo (rt2),
        .rt_hi (rt3),
        .hit   (hit_b)
    );

    // Merge the two banks per line.
    always_comb line_next = hit_a | hit_b;

    // Output register: lines follow their inputs one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) line_out <= '0;
        else        line_out <= line_next;
    end

    // R4: with every enable bit clear, no line rises on the next cycle.
    a_r4_all_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a == '0 && en_b == '0) |=> (line_out == '0))
        else $error("a_r4_all_disabled_quiet");

    // R6: with no request raised, all lines are low one clock later.
    a_r6_no_request_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a == '0 && src_b == '0) |=> (line_out == '0))
        else $error("a_r6_no_request_quiet");
endmodule

// File: tb/irq_steer_tb_top.sv
module irq_steer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_a = '0, src_b = '0;
    logic        bus_sel_a = 1'b0, bus_sel_b = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [4:0]  line_out;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    irq_steer dut_i (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .bus_sel_a(bus_sel_a), .bus_sel_b(bus_sel_b), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_out(line_out)
    );

    // Behavioural reference model of the programmer-visible state.
    logic [15:0] m_en [2];
    logic [15:0] m_rt [4];
    logic [4:0]  exp_line = '0;

    function automatic logic [4:0] model_lines();
        logic [4:0] res = '0;
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 16; s++) begin
                int code;
                bit req = (b == 0) ? src_a[s] : src_b[s];
                if (s < 10) code = int'((m_rt[b*2 + s/5] >> (3*(s%5))) & 16'h7);
                else        code = 0;
                if (req && m_en[b][s] && code < 5) res[code] = 1'b1;
            end
        end
        return res;
    endfunction

    // Model update at each clock edge: next expected lines, then writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en[0] = '0; m_en[1] = '0;
            m_rt[0] = 16'h0040; m_rt[1] = '0; m_rt[2] = 16'h00C2; m_rt[3] = '0;
            exp_line = '0;
        end else begin
            exp_line = model_lines();
            if (bus_wr && bus_sel_a) begin
                case (bus_addr)
                    5'h04: m_rt[0] = bus_wdata & 16'h7FFF;
                    5'h06: m_rt[1] = bus_wdata & 16'h7FFF;
                    5'h0C: m_en[0] = bus_wdata;
                    5'h1C: m_rt[2] = bus_wdata & 16'h7FFF;
                    5'h1E: m_rt[3] = bus_wdata & 16'h7FFF;
                    default: ;
                endcase
            end else if (bus_wr && bus_sel_b && bus_addr == 5'h06) begin
                m_en[1] = bus_wdata;
            end
        end
    end

    // Every-clock comparison of the lines against the model.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            n_chk++;
            if (line_out !== exp_line) begin
                n_bad++;
                $display("FAIL R4 R6 model compare t=%0t actual=%b expected=%b", $time, line_out, exp_line);
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input bit a, input bit b, input logic [4:0] addr, input logic [15:0] data);
        @(negedge clk);
        bus_sel_a = a; bus_sel_b = b; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel_a = 1'b0; bus_sel_b = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input bit a, input bit b, input logic [4:0] addr, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_sel_a = a; bus_sel_b = b; bus_wr = 1'b0; bus_addr = addr;
        #1;
        check(tag, bus_rdata, exp);
        bus_sel_a = 1'b0; bus_sel_b = 1'b0;
    endtask

    task automatic set_src(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        src_a = a; src_b = b;
    endtask

    task automatic check_line(input logic [4:0] exp, input string tag);
        @(negedge clk);
        @(negedge clk);
        #1;
        check(tag, 16'(line_out), 16'(exp));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        #1;
        check("R1 line_out after reset", 16'(line_out), 16'h0);
        bus_read(1, 0, 5'h04, 16'h0040, "R1 steer0 reset");
        bus_read(1, 0, 5'h06, 16'h0000, "R1 steer1 reset");
        bus_read(1, 0, 5'h1C, 16'h00C2, "R1 steer2 reset");
        bus_read(1, 0, 5'h1E, 16'h0000, "R1 steer3 reset");
        bus_read(1, 0, 5'h0C, 16'h0000, "R1 enable A reset");
        bus_read(0, 1, 5'h06, 16'h0000, "R1 enable B reset");

        // Raised but disabled requests; live request reads.
        set_src(16'hA5A5, 16'h5A5A);
        check_line(5'b00000, "R1 all disabled");
        bus_read(1, 0, 5'h00, 16'hA5A5, "R7 request A live");
        bus_read(0, 1, 5'h00, 16'h5A5A, "R7 request B live");
        bus_write(1, 0, 5'h00, 16'h1234);
        bus_read(1, 0, 5'h00, 16'hA5A5, "R7 request write ignored");
        bus_read(1, 0, 5'h0C, 16'h0000, "R7 request write left enable");

        // One-clock latency from a request change.
        set_src(16'h0000, 16'h0000);
        bus_write(1, 0, 5'h0C, 16'h0004);
        check_line(5'b00000, "R4 enabled but idle");
        @(negedge clk);
        src_a = 16'h0004;
        #1;
        check("R6 no change before edge", 16'(line_out), 16'h0);
        @(negedge clk);
        #1;
        check("R6 change after one edge", 16'(line_out), 16'b00010);

        // Several lines at once from both banks.
        set_src(16'h0004, 16'hFFFF);
        bus_write(0, 1, 5'h06, 16'h0005);
        check_line(5'b01110, "R4 default steering lines 1 2 3");
        bus_read(0, 1, 5'h06, 16'h0005, "R8 enable B readback");

        // Field position: bank A source 7 uses steer1 bits 8:6.
        bus_write(1, 0, 5'h06, 16'h0100);
        bus_write(1, 0, 5'h0C, 16'h0080);
        bus_write(0, 1, 5'h06, 16'h0000);
        set_src(16'h0080, 16'h0000);
        check_line(5'b10000, "R3 A src7 to line 4");
        bus_read(1, 0, 5'h06, 16'h0100, "R8 steer1 readback");

        // Unrouted code.
        bus_write(1, 0, 5'h06, 16'h01C0);
        check_line(5'b00000, "R5 code 7 drives nothing");
        bus_write(1, 0, 5'h06, 16'h0140);
        check_line(5'b00000, "R5 code 5 drives nothing");

        // Bank B source 5 uses steer3 bits 2:0.
        bus_write(1, 0, 5'h0C, 16'h0000);
        bus_write(1, 0, 5'h1E, 16'h0003);
        bus_write(0, 1, 5'h06, 16'h0020);
        set_src(16'h0000, 16'h0020);
        check_line(5'b01000, "R3 B src5 to line 3");

        // Sources above 9 are fixed to line 0; bit 15 reads zero.
        bus_write(0, 1, 5'h06, 16'h1000);
        bus_write(1, 0, 5'h1E, 16'hFFFF);
        set_src(16'h0000, 16'h1000);
        check_line(5'b00001, "R3 B src12 fixed line 0");
        bus_read(1, 0, 5'h1E, 16'h7FFF, "R3 steer3 bit 15 zero");

        // Address decode.
        bus_read(1, 0, 5'h02, 16'h0000, "R2 unmapped A read");
        bus_write(1, 0, 5'h02, 16'hFFFF);
        bus_read(1, 0, 5'h02, 16'h0000, "R2 unmapped A write");
        bus_read(0, 1, 5'h04, 16'h0000, "R2 unmapped B read");
        bus_write(0, 1, 5'h1C, 16'h0000);
        bus_read(1, 0, 5'h1C, 16'h00C2, "R2 B window has no steer2");
        bus_read(0, 0, 5'h04, 16'h0000, "R2 no select reads zero");
        bus_write(1, 1, 5'h06, 16'h0015);
        bus_read(1, 0, 5'h06, 16'h0015, "R2 dual select writes A");
        bus_read(0, 1, 5'h06, 16'h1000, "R2 dual select leaves B");

        // Random traffic against the model.
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            src_a = 16'($urandom);
            src_b = 16'($urandom);
            bus_wr = 1'b0; bus_sel_a = 1'b0; bus_sel_b = 1'b0;
            if (($urandom % 3) == 0) begin
                int pick = int'($urandom % 8);
                case (pick)
                    0: bus_addr = 5'h00;
                    1: bus_addr = 5'h04;
                    2: bus_addr = 5'h06;
                    3: bus_addr = 5'h0C;
                    4: bus_addr = 5'h1C;
                    5: bus_addr = 5'h1E;
                    6: bus_addr = 5'h02;
                    default: bus_addr = 5'h06;
                endcase
                bus_sel_a = ($urandom % 2) == 0;
                bus_sel_b = ($urandom % 2) == 0;
                bus_wdata = 16'($urandom);
                bus_wr = 1'b1;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_sel_a = 1'b0; bus_sel_b = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule